// File: doc/BRIEF.md
# Windowed Range Up-Counter with Lead-In

This block is a synchronous binary up-counter whose steady-state sequence is confined to a window of decimal values, by default 400 through 500. It has two start behaviours, which are chosen when reset is applied.

- In direct mode the counter opens at the bottom of the window.
- In lead-in mode it first climbs from zero all the way to the top of the window.

In both modes the counter then falls back to the bottom of the window and cycles there for as long as it is enabled.

Next to the binary count, the block presents the same value as packed decimal digits, ready for a set of seven-segment decoders. It also raises a one-cycle pulse each time the count drops from the top of the window back to its bottom. The count advances once per enabled clock, so the counting rate follows the clock frequency directly; the intended count clock is about 1 kHz.

The control is a two-state machine with a count register.

- State `PH_LEADIN` is entered on reset when lead-in mode is requested. It stays there while the count climbs from zero.
- State `PH_WINDOW` is entered on reset in direct mode. It is also entered from `PH_LEADIN` by the transition "top reached", which happens on an enabled clock with the count at the window top.
- `PH_WINDOW` only ever leaves through reset.

Top module: `win_cnt`

## Requirements
- R1: The count is a plain unsigned binary value whose bit 0 is the least significant bit. Each enabled clock that does not start at the window top raises it by exactly one.
- R2: A reset taken with `mode_leadin` low makes the count 400 (binary 110010000) on the following cycle.
- R3: A reset taken with `mode_leadin` high makes the count 0 on the following cycle. From there it rises one per enabled clock up to 500 and never exceeds 500.
- R4: In both modes, an enabled clock at count 500 (binary 111110100) makes the next count 400. The 400..500 cycle then repeats indefinitely.
- R5: `wrap` is high for exactly the one cycle in which the count shows 400 right after 500, and is low in every other cycle. This includes the cycle in which the lead-in pass goes through 400 from 399, and the cycle after reset.
- R6: While `en` is low, the count holds its value and `wrap` is low.
- R7: `mode_leadin` is sampled only on a reset clock. Changing it while counting has no effect on the count sequence until the next reset.
- R8: `bcd` carries the decimal value of the count in the same cycle as the count: hundreds in bits 11:8, tens in bits 7:4, units in bits 3:0. Every digit lies in 0..9.
- R9: Reset is synchronous, active high, and takes priority over `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; the count holds when low |
| mode_leadin | input | 1 | Start mode taken at reset: 1 starts from zero, 0 starts at the window bottom |
| count | output | 9 | Binary count value |
| wrap | output | 1 | One-cycle pulse on the fall from the window top to the window bottom |
| bcd | output | 12 | Packed decimal digits of the count: hundreds, tens, units |

## Verification
The bench builds the block with its default parameters: a 9-bit count, a window of 400..500 and three decimal digits. With these values, a full lead-in pass from 0 to 500 takes only 500 enabled clocks, so the bench can walk the complete climb through 400 (where no pulse may appear) and several window wraps within a short run. Every value of the window is exercised, along with every value 0..500 of the decimal conversion, including the 99/100 and 499/500 digit carries. Enable gaps, a mid-count change of mode, and a reset taken with the enable still high are mixed into the sequence.

// File: rtl/win_cnt_pkg.sv
package win_cnt_pkg;

    // Phase of the windowed counter
    typedef enum logic [0:0] {
        PH_LEADIN = 1'b0,  // climbing from zero toward the window top
        PH_WINDOW = 1'b1   // cycling inside the window
    } phase_t;

endpackage

// File: rtl/win_cnt_bcd.sv
module win_cnt_bcd #(
    parameter int W   = 9,
    parameter int DIG = 3
) (
    input  logic [W-1:0]       bin,
    output logic [4*DIG-1:0]   bcd
);

    localparam int AW = W + 4*DIG;

    logic [AW-1:0] acc;

    // Shift-and-add-three conversion, unrolled over the input bits
    always_comb begin
        acc = '0;
        acc[W-1:0] = bin;
        for (int i = 0; i < W; i++) begin
            for (int d = 0; d < DIG; d++) begin
                if (acc[W + 4*d +: 4] >= 4'd5) begin
                    acc[W + 4*d +: 4] = acc[W + 4*d +: 4] + 4'd3;
                end
            end
            acc = acc << 1;
        end
        bcd = acc[W +: 4*DIG];
    end

endmodule

// File: rtl/win_cnt_seq.sv
module win_cnt_seq
    import win_cnt_pkg::*;
#(
    parameter int W  = 9,
    parameter int LO = 400,
    parameter int HI = 500
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         mode_leadin,
    output logic [W-1:0] count,
    output logic         wrap,
    output phase_t       phase
);

    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    phase_t phase_nxt;
    logic   at_top;

    assign at_top = (count == HI_V);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= mode_leadin ? PH_LEADIN : PH_WINDOW;
        end else begin
            phase <= phase_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_LEADIN: if (en && at_top) phase_nxt = PH_WINDOW;  // top reached
            PH_WINDOW: phase_nxt = PH_WINDOW;
            default:   phase_nxt = PH_WINDOW;
        endcase
    end

    // Output registers: count and wrap pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= mode_leadin ? '0 : LO_V;
            wrap  <= 1'b0;
        end else if (en) begin
            if (at_top) begin
                count <= LO_V;
                wrap  <= 1'b1;
            end else begin
                count <= count + W'(1);
                wrap  <= 1'b0;
            end
        end else begin
            wrap <= 1'b0;
        end
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (en && count != HI_V) |=> (count == $past(count) + W'(1))); // R1
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WINDOW) |-> (count >= LO_V && count <= HI_V)); // R4
    AST_LEADIN_CEIL: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LEADIN) |-> (count <= HI_V)); // R3
    AST_TOP_TO_LO: assert property (@(posedge clk) disable iff (rst)
        (en && count == HI_V) |=> (count == LO_V && wrap)); // R4
    AST_WRAP_AT_LO: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (count == LO_V && phase == PH_WINDOW)); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(count) && !wrap)); // R6

endmodule

// File: rtl/win_cnt.sv
module win_cnt
    import win_cnt_pkg::*;
#(
    parameter int W   = 9,
    parameter int LO  = 400,
    parameter int HI  = 500,
    parameter int DIG = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             mode_leadin,
    output logic [W-1:0]     count,
    output logic             wrap,
    output logic [4*DIG-1:0] bcd
);

    localparam logic [W-1:0] LO_V = W'(LO);

    phase_t phase;

    win_cnt_seq #(
        .W  (W),
        .LO (LO),
        .HI (HI)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .mode_leadin (mode_leadin),
        .count       (count),
        .wrap        (wrap),
        .phase       (phase)
    );

    win_cnt_bcd #(
        .W   (W),
        .DIG (DIG)
    ) u_bcd (
        .bin (count),
        .bcd (bcd)
    );

    AST_RESET_DIRECT: assert property (@(posedge clk)
        (rst && !mode_leadin) |=> (count == LO_V && !wrap)); // R2
    AST_RESET_LEADIN: assert property (@(posedge clk)
        (rst && mode_leadin) |=> (count == '0 && !wrap)); // R3

    for (genvar g = 0; g < DIG; g++) begin : g_digit_chk
        AST_BCD_DIGIT: assert property (@(posedge clk) disable iff (rst)
            (bcd[4*g +: 4] <= 4'd9)); // R8
    end

endmodule

// File: tb/win_cnt_bench.sv
module win_cnt_bench;

    localparam int W  = 9;
    localparam int LO = 400;
    localparam int HI = 500;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        mode_leadin = 1'b0;
    logic [8:0]  count;
    logic        wrap;
    logic [11:0] bcd;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_cnt = 0;
    int m_wrap = 0;
    bit m_valid = 0;
    int m_wraps = 0;
    int seen_wraps = 0;

    always #2 clk = ~clk;

    win_cnt u_win_cnt (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .mode_leadin (mode_leadin),
        .count       (count),
        .wrap        (wrap),
        .bcd         (bcd)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int to_bcd(input int v);
        return ((v / 100) << 8) | (((v / 10) % 10) << 4) | (v % 10);
    endfunction

    // Behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_cnt  = mode_leadin ? 0 : LO;
            m_wrap = 0;
            m_valid = 1;
        end else if (en) begin
            if (m_cnt == HI) begin
                m_cnt = LO;
                m_wrap = 1;
                m_wraps++;
            end else begin
                m_cnt = m_cnt + 1;
                m_wrap = 0;
            end
        end else begin
            m_wrap = 0;
        end
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (m_valid && !done) begin
            chk(int'(count), m_cnt, "R1 R4 count");
            chk(int'(wrap), m_wrap, "R5 wrap");
            chk(int'(bcd), to_bcd(m_cnt), "R8 bcd");
            if (wrap === 1'b1) seen_wraps++;
        end
    end

    initial begin
        // Direct mode reset
        rst = 1'b1; mode_leadin = 1'b0; en = 1'b0;
        repeat (2) @(negedge clk);
        chk(int'(count), 400, "R2 direct start");
        chk(int'(wrap), 0, "R5 no pulse after reset");
        chk(int'(bcd), 12'h400, "R8 digits at 400");
        rst = 1'b0; en = 1'b1;
        repeat (60) @(negedge clk);
        chk(int'(count), 460, "R1 after 60 counts");

        // Hold and mid-count mode change
        en = 1'b0; mode_leadin = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(int'(count), 460, "R6 hold");
            chk(int'(wrap), 0, "R6 no pulse while idle");
        end

        // Gapped enable, through several wraps
        for (int k = 0; k < 260; k++) begin
            en = (k % 4) != 3;
            @(negedge clk);
        end
        chk(int'(count), m_cnt, "R7 mode change ignored");
        chk(seen_wraps, m_wraps, "R5 wrap tally");

        // Reset in lead-in mode with enable still high
        en = 1'b1; rst = 1'b1; mode_leadin = 1'b1;
        @(negedge clk);
        chk(int'(count), 0, "R3 R9 leadin start");
        chk(int'(bcd), 0, "R8 digits at 0");
        rst = 1'b0; mode_leadin = 1'b0;
        repeat (99) @(negedge clk);
        chk(int'(bcd), 12'h099, "R8 digits at 99");
        @(negedge clk);
        chk(int'(bcd), 12'h100, "R8 digits at 100");
        repeat (300) @(negedge clk);
        chk(int'(count), 400, "R3 climb to 400");
        chk(int'(wrap), 0, "R5 no pulse on climb");
        repeat (99) @(negedge clk);
        chk(int'(bcd), 12'h499, "R8 digits at 499");
        @(negedge clk);
        chk(int'(count), 500, "R3 top reached");
        @(negedge clk);
        chk(int'(count), 400, "R4 back to bottom");
        chk(int'(wrap), 1, "R5 pulse on wrap");
        @(negedge clk);
        chk(int'(count), 401, "R4 window repeats");
        chk(int'(wrap), 0, "R5 pulse one cycle");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule